// File: doc/BRIEF.md
# Flash Status Register and Write-Protection Guard

This block keeps the status byte of a serial flash device and decides, for every program or erase request, whether it may run. The command front end hands it one-cycle strobes for write-enable, write-disable, status write (with its data byte), sector erase, block erase, chip erase and page program, together with the target byte address. The program/erase engines hand back a done pulse. One cycle after each write-type strobe the block answers with either a grant pulse, which starts the engine, or an ignore pulse, which means nothing happens.

Protection is a contiguous run of 64 KB blocks chosen by three range bits and a bottom/top select bit. A lock bit, together with the active-low write-protect pin, can freeze the protection fields. The protected run is also driven out as first and last block indices so the surrounding logic and the bench can see it directly. If several strobes arrive in one cycle, status write wins over chip erase, then block erase, sector erase, page program, write-disable and write-enable.

Top module: `flash_status_guard`

## Requirements
- R1: After reset the status byte is 00h, grant and ignore are low, and no block is reported protected.
- R2: The status byte reads bit0 busy, bit1 write-enable latch, bits 4:2 range code, bit5 bottom select, bit6 constant 0, bit7 lock.
- R3: While not busy, a write-enable strobe sets the latch and a write-disable strobe clears it, visible one cycle later.
- R4: A status write, erase or program strobe is ignored (ignore pulse, state unchanged) when the latch is 0 or busy is 1; write-enable and write-disable have no effect while busy.
- R5: A granted write pulses grant one cycle after the strobe with busy set in that same cycle; a done pulse while busy clears both busy and the latch, and a done pulse while idle changes nothing.
- R6: A granted status write loads data bits 7, 5, 4, 3, 2 into the lock, bottom select and range fields; data bits 6, 1, 0 are dropped.
- R7: A status write is ignored when the write-protect pin is low and lock is 1; with the pin low and lock 0 one write may set lock and change the other fields together.
- R8: Range code 000 protects nothing; any code with bit 2 set protects all 8 blocks; codes 001, 010, 011 protect 1, 2, 4 blocks, at the top end (blocks 7, 6-7, 4-7) with bottom select 0 and at the bottom end (0, 0-1, 0-3) with bottom select 1.
- R9: Sector erase, block erase and page program are ignored when the address bits 18:16 name a protected block and granted otherwise.
- R10: Chip erase is granted only when the range code is 000.
- R11: The protected-any flag and first/last block indices always describe the range of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, low enables the lock |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_sec_erase | input | 1 | Sector erase strobe |
| cmd_blk_erase | input | 1 | Block erase strobe |
| cmd_chip_erase | input | 1 | Chip erase strobe |
| cmd_page_prog | input | 1 | Page program strobe |
| cmd_addr | input | 19 | Target byte address of erase/program |
| op_done | input | 1 | Completion pulse from the engines |
| status_byte | output | 8 | Current status byte |
| op_grant | output | 1 | Write request accepted, engine may start |
| op_ignore | output | 1 | Write request dropped |
| prot_any | output | 1 | At least one block is protected |
| prot_lo_blk | output | 3 | First protected block |
| prot_hi_blk | output | 3 | Last protected block |

## Verification
A wrong range code, bottom select or lock value shows up in the status byte and in the protected-block outputs in the very next cycle after the status write is granted, and in every later grant/ignore decision. A wrong latch or busy bit shows as a grant where an ignore belongs, or the reverse, one cycle after the offending strobe. The sweep covers every range code with both end selections against every block for all three address-based operations plus chip erase, so a single mis-decoded block boundary produces a mismatch.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  // status byte bit positions; the front end shifts this byte out as-is
  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_RNG0 = 2;
  localparam int BIT_BOT  = 5;
  localparam int BIT_LOCK = 7;

  // only these bits may be loaded by a status write
  localparam logic [7:0] WR_MASK = 8'b1011_1100;

  typedef enum logic [2:0] {
    W_NONE,
    W_STAT,
    W_CHIP,
    W_BLK,
    W_SEC,
    W_PROG
  } wsel_e;

  // number of protected blocks for range codes 1..3
  function automatic logic [3:0] span_of(input logic [1:0] code);
    return 4'd1 << (code - 2'd1);
  endfunction

  // lock check: a status write is refused only when pin low and lock set
  function automatic logic stat_write_ok(input logic pin_n, input logic lock);
    return pin_n | ~lock;
  endfunction

endpackage

// File: rtl/fsg_range.sv
module fsg_range #(
  parameter int ADDR_W = 19,
  parameter int BLK_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        rng_code,
  input  logic              bot_sel,
  input  logic [ADDR_W-1:0] tgt_addr,
  output logic              any_prot,
  output logic [BLK_W-1:0]  lo_blk,
  output logic [BLK_W-1:0]  hi_blk,
  output logic              tgt_hit
);
  import fsg_pkg::*;

  localparam int OFS_W = ADDR_W - BLK_W;
  localparam logic [BLK_W:0] NBLK = {1'b1, {BLK_W{1'b0}}};

  logic [BLK_W:0]  span;
  logic [ADDR_W-1:0] lo_addr;
  logic [ADDR_W-1:0] hi_addr;

  always_comb begin
    span     = (BLK_W+1)'(span_of(rng_code[1:0]));
    any_prot = 1'b0;
    lo_blk   = '0;
    hi_blk   = '0;
    if (rng_code[2]) begin
      any_prot = 1'b1;
      lo_blk   = '0;
      hi_blk   = '1;
    end else if (rng_code[1:0] != 2'b00) begin
      any_prot = 1'b1;
      if (bot_sel) begin
        lo_blk = '0;
        hi_blk = BLK_W'(span - 1'b1);
      end else begin
        lo_blk = BLK_W'(NBLK - span);
        hi_blk = '1;
      end
    end
  end

  // compare at byte-address level against the run's outer bounds
  assign lo_addr = {lo_blk, {OFS_W{1'b0}}};
  assign hi_addr = {hi_blk, {OFS_W{1'b1}}};
  assign tgt_hit = any_prot && (tgt_addr >= lo_addr) && (tgt_addr <= hi_addr);

  p_range_order_r11: assert property (@(posedge clk) disable iff (!rst_n)
    any_prot |-> (lo_blk <= hi_blk));

  p_full_cover_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rng_code[2] |-> (lo_blk == '0 && hi_blk == '1));

  p_hit_inside_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_hit |-> any_prot);

endmodule

// File: rtl/fsg_decide.sv
module fsg_decide (
  input  logic cmd_wren,
  input  logic cmd_wrdi,
  input  logic cmd_wrsr,
  input  logic cmd_chip,
  input  logic cmd_blk,
  input  logic cmd_sec,
  input  logic cmd_prog,
  input  logic wel,
  input  logic busy,
  input  logic wp_n,
  input  logic lock,
  input  logic rng_zero,
  input  logic tgt_hit,
  output logic grant_now,
  output logic ignore_now,
  output logic stat_load,
  output logic wel_set,
  output logic wel_clr
);
  import fsg_pkg::*;

  wsel_e sel;
  logic  allowed;

  always_comb begin
    if (cmd_wrsr)      sel = W_STAT;
    else if (cmd_chip) sel = W_CHIP;
    else if (cmd_blk)  sel = W_BLK;
    else if (cmd_sec)  sel = W_SEC;
    else if (cmd_prog) sel = W_PROG;
    else               sel = W_NONE;
  end

  always_comb begin
    unique case (sel)
      W_STAT:  allowed = stat_write_ok(wp_n, lock);
      W_CHIP:  allowed = rng_zero;
      W_BLK,
      W_SEC,
      W_PROG:  allowed = ~tgt_hit;
      default: allowed = 1'b0;
    endcase
  end

  assign grant_now  = (sel != W_NONE) && wel && !busy && allowed;
  assign ignore_now = (sel != W_NONE) && !grant_now;
  assign stat_load  = grant_now && (sel == W_STAT);
  assign wel_clr    = (sel == W_NONE) && !busy && cmd_wrdi;
  assign wel_set    = (sel == W_NONE) && !busy && !cmd_wrdi && cmd_wren;

endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard #(
  parameter int ADDR_W = 19,
  parameter int BLK_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic              cmd_sec_erase,
  input  logic              cmd_blk_erase,
  input  logic              cmd_chip_erase,
  input  logic              cmd_page_prog,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              op_done,
  output logic [7:0]        status_byte,
  output logic              op_grant,
  output logic              op_ignore,
  output logic              prot_any,
  output logic [BLK_W-1:0]  prot_lo_blk,
  output logic [BLK_W-1:0]  prot_hi_blk
);
  import fsg_pkg::*;

  // protection image: only WR_MASK bits are ever non-zero
  logic [7:0] sr_img;
  logic       busy_q;
  logic       wel_q;

  logic [2:0] rng_code;
  logic       bot_sel;
  logic       lock_bit;
  logic       tgt_hit;
  logic       grant_now;
  logic       ignore_now;
  logic       stat_load;
  logic       wel_set;
  logic       wel_clr;
  logic       any_write;
  logic       done_take;

  assign rng_code  = sr_img[BIT_RNG0 +: 3];
  assign bot_sel   = sr_img[BIT_BOT];
  assign lock_bit  = sr_img[BIT_LOCK];
  assign any_write = cmd_wrsr | cmd_chip_erase | cmd_blk_erase | cmd_sec_erase | cmd_page_prog;
  assign done_take = busy_q && op_done;

  fsg_range #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_range (
    .clk      (clk),
    .rst_n    (rst_n),
    .rng_code (rng_code),
    .bot_sel  (bot_sel),
    .tgt_addr (cmd_addr),
    .any_prot (prot_any),
    .lo_blk   (prot_lo_blk),
    .hi_blk   (prot_hi_blk),
    .tgt_hit  (tgt_hit)
  );

  fsg_decide u_decide (
    .cmd_wren   (cmd_wren),
    .cmd_wrdi   (cmd_wrdi),
    .cmd_wrsr   (cmd_wrsr),
    .cmd_chip   (cmd_chip_erase),
    .cmd_blk    (cmd_blk_erase),
    .cmd_sec    (cmd_sec_erase),
    .cmd_prog   (cmd_page_prog),
    .wel        (wel_q),
    .busy       (busy_q),
    .wp_n       (wp_n),
    .lock       (lock_bit),
    .rng_zero   (rng_code == 3'b000),
    .tgt_hit    (tgt_hit),
    .grant_now  (grant_now),
    .ignore_now (ignore_now),
    .stat_load  (stat_load),
    .wel_set    (wel_set),
    .wel_clr    (wel_clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_img    <= '0;
      busy_q    <= 1'b0;
      wel_q     <= 1'b0;
      op_grant  <= 1'b0;
      op_ignore <= 1'b0;
    end else begin
      op_grant  <= grant_now;
      op_ignore <= ignore_now;
      if (done_take) begin
        busy_q <= 1'b0;
        wel_q  <= 1'b0;
      end else begin
        if (grant_now) busy_q <= 1'b1;
        if (wel_set)      wel_q <= 1'b1;
        else if (wel_clr) wel_q <= 1'b0;
      end
      if (stat_load) sr_img <= wrsr_data & WR_MASK;
    end
  end

  assign status_byte = sr_img | {6'b0, wel_q, busy_q};

  p_busy_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && any_write) |=> (op_ignore && !op_grant));

  p_latch_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wel_q && any_write) |=> op_ignore);

  p_grant_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_grant |-> status_byte[BIT_BUSY]);

  p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[BIT_BUSY] && op_done) |=> (!status_byte[BIT_BUSY] && !status_byte[BIT_WEL]));

  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && lock_bit && cmd_wrsr) |=> $stable(sr_img));

  p_chip_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_chip_erase && !cmd_wrsr && rng_code != 3'b000) |=> !op_grant);

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_grant && op_ignore));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[6] == 1'b0);

endmodule

// File: tb/sim_flash_status_guard.sv
module sim_flash_status_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n = 1'b1;
  logic        cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0;
  logic [7:0]  wrsr_data = 8'h00;
  logic        cmd_sec_erase = 1'b0, cmd_blk_erase = 1'b0;
  logic        cmd_chip_erase = 1'b0, cmd_page_prog = 1'b0;
  logic [18:0] cmd_addr = '0;
  logic        op_done = 1'b0;
  logic [7:0]  status_byte;
  logic        op_grant, op_ignore, prot_any;
  logic [2:0]  prot_lo_blk, prot_hi_blk;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  flash_status_guard u0 (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .wrsr_data(wrsr_data), .cmd_sec_erase(cmd_sec_erase),
    .cmd_blk_erase(cmd_blk_erase), .cmd_chip_erase(cmd_chip_erase),
    .cmd_page_prog(cmd_page_prog), .cmd_addr(cmd_addr), .op_done(op_done),
    .status_byte(status_byte), .op_grant(op_grant), .op_ignore(op_ignore),
    .prot_any(prot_any), .prot_lo_blk(prot_lo_blk), .prot_hi_blk(prot_hi_blk)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // op: 0 wren, 1 wrdi, 2 status write, 3 sector, 4 block, 5 program, 6 chip
  task automatic issue(input int op, input int addr, input logic [7:0] d);
    @(negedge clk);
    cmd_addr  = 19'(addr);
    wrsr_data = d;
    cmd_wren       = (op == 0);
    cmd_wrdi       = (op == 1);
    cmd_wrsr       = (op == 2);
    cmd_sec_erase  = (op == 3);
    cmd_blk_erase  = (op == 4);
    cmd_page_prog  = (op == 5);
    cmd_chip_erase = (op == 6);
    @(negedge clk);
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_sec_erase, cmd_blk_erase, cmd_page_prog, cmd_chip_erase} = '0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  function automatic bit exp_prot(input bit bot, input bit [2:0] code, input int blk);
    int n;
    if (code[2]) return 1'b1;
    if (code == 3'd0) return 1'b0;
    n = (code == 3'd1) ? 1 : (code == 3'd2) ? 2 : 4;
    return bot ? (blk < n) : (blk >= 8 - n);
  endfunction

  // loads a protection image with the pin high and finishes the write
  task automatic set_cfg(input logic [7:0] d);
    issue(0, 0, 8'h00);
    issue(2, 0, d);
    chk("R6 grant", op_grant, 1);
    done_pulse();
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", status_byte, 8'h00);
    chk("R1 grant", op_grant, 0);
    chk("R1 ignore", op_ignore, 0);
    chk("R1 prot_any", prot_any, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after release", status_byte, 8'h00);

    // R3 latch set/clear
    issue(0, 0, 8'h00);
    chk("R3 wren", status_byte, 8'h02);
    issue(1, 0, 8'h00);
    chk("R3 wrdi", status_byte, 8'h00);

    // R4 no latch
    issue(3, 19'h10000, 8'h00);
    chk("R4 ignore without latch", op_ignore, 1);
    chk("R4 state unchanged", status_byte, 8'h00);
    issue(2, 0, 8'h9C);
    chk("R4 status write without latch", op_ignore, 1);
    chk("R4 image unchanged", status_byte, 8'h00);

    // R8 R9 R10 R11 sweep over every configuration and block
    for (int bot = 0; bot < 2; bot++) begin
      for (int code = 0; code < 8; code++) begin
        logic [7:0] base;
        int lo, hi;
        bit any;
        base = 8'((bot << 5) | (code << 2));
        set_cfg(base | 8'h43);
        chk("R6 R2 image", status_byte, base);
        any = 0; lo = 0; hi = 0;
        for (int b = 7; b >= 0; b--) if (exp_prot(bot[0], 3'(code), b)) begin any = 1; lo = b; end
        for (int b = 0; b < 8; b++) if (exp_prot(bot[0], 3'(code), b)) hi = b;
        chk("R11 any", prot_any, any);
        if (any) begin
          chk("R11 R8 lo", prot_lo_blk, lo);
          chk("R11 R8 hi", prot_hi_blk, hi);
        end
        for (int op = 3; op <= 5; op++) begin
          for (int b = 0; b < 8; b++) begin
            int addr;
            bit p;
            addr = (b << 16) | ((b * 4099 + op * 257) & 16'hFFFF);
            p = exp_prot(bot[0], 3'(code), b);
            issue(0, 0, 8'h00);
            issue(op, addr, 8'h00);
            chk("R9 grant", op_grant, !p);
            chk("R9 ignore", op_ignore, p);
            if (!p) begin
              chk("R5 busy set", status_byte, base | 8'h03);
              done_pulse();
              chk("R5 done clears", status_byte, base);
            end else begin
              chk("R9 latch kept", status_byte, base | 8'h02);
              issue(1, 0, 8'h00);
            end
          end
        end
        issue(0, 0, 8'h00);
        issue(6, 0, 8'h00);
        chk("R10 chip grant", op_grant, code == 0);
        if (code == 0) done_pulse();
        else issue(1, 0, 8'h00);
        chk("R10 after chip", status_byte, base);
      end
    end

    // R5 R4 busy behaviour
    set_cfg(8'h00);
    issue(0, 0, 8'h00);
    issue(5, 19'h12345, 8'h00);
    chk("R5 grant", op_grant, 1);
    chk("R5 busy", status_byte, 8'h03);
    issue(1, 0, 8'h00);
    chk("R4 wrdi while busy", status_byte, 8'h03);
    issue(3, 19'h00000, 8'h00);
    chk("R4 ignore while busy", op_ignore, 1);
    chk("R4 busy unchanged", status_byte, 8'h03);
    done_pulse();
    chk("R5 done", status_byte, 8'h00);
    issue(0, 0, 8'h00);
    done_pulse();
    chk("R5 idle done no effect", status_byte, 8'h02);
    issue(1, 0, 8'h00);

    // R7 lock with the pin
    set_cfg(8'h84);
    chk("R7 lock set", status_byte, 8'h84);
    wp_n = 1'b0;
    issue(0, 0, 8'h00);
    issue(2, 0, 8'h00);
    chk("R7 locked write ignored", op_ignore, 1);
    chk("R7 image kept", status_byte, 8'h86);
    issue(1, 0, 8'h00);
    wp_n = 1'b1;
    set_cfg(8'h00);
    chk("R7 pin high unlock", status_byte, 8'h00);
    wp_n = 1'b0;
    set_cfg(8'hA8);
    chk("R7 set lock with pin low", status_byte, 8'hA8);
    chk("R8 bottom two lo", prot_lo_blk, 0);
    chk("R8 bottom two hi", prot_hi_blk, 1);
    issue(0, 0, 8'h00);
    issue(2, 0, 8'h00);
    chk("R7 cannot clear lock", op_ignore, 1);
    chk("R7 image after refusal", status_byte, 8'hAA);
    wp_n = 1'b1;
    issue(2, 0, 8'h43);
    chk("R6 grant with pin high", op_grant, 1);
    done_pulse();
    chk("R6 reserved and low bits dropped", status_byte, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule